// File: doc/BRIEF.md
# Dual-Polarity Reset Pulse Stretcher

This block turns three untidy reset sources into one clean system reset of a guaranteed minimum length. The sources are a supply-good flag from an on-chip comparator, which arrives already synchronous to the block clock, plus an active-low and an active-high reset request from outside the chip. The two external requests are asynchronous. Each source passes through a digital glitch filter. The external requests are first brought into the clock domain by a two-flop synchroniser.

Any filtered request loads a single shared timeout counter and holds the internal reset state asserted. The state is released only after the counter has run for the full timeout with no request present. The internal reset state drives two outputs at once: one active-high and one active-low. The timeout length and the glitch-reject width are parameters counted in clock cycles. At 250 MHz the defaults are 50,000,000 cycles, which is 200 ms, and 8 cycles, which is 32 ns.

Top module: `rps_top`

## Requirements
- R1: While `rst_n` is low, `sys_rst_o` is 1. After `rst_n` is sampled high, `sys_rst_o` stays 1 for exactly TIMEOUT_CYC-1 further clock edges and falls on edge TIMEOUT_CYC, provided no request is present.
- R2: `sys_rst_n_o` is always the logical complement of `sys_rst_o`.
- R3: A low level on `supply_ok_i` (0 = supply below threshold) that lasts fewer than GLITCH_CYC consecutive clock samples has no effect on either output.
- R4: When `supply_ok_i` is sampled low for GLITCH_CYC or more consecutive edges, `sys_rst_o` rises GLITCH_CYC+1 edges after the first low sample. It stays high for as long as the supply stays low.
- R5: After `supply_ok_i` returns high, the reset is released TIMEOUT_CYC edges after the first edge that samples it high. A request of N ≥ GLITCH_CYC cycles therefore gives a reset of N+TIMEOUT_CYC-GLITCH_CYC cycles.
- R6: An active-low request on `ext_rst_n_i` (0 = request) that is held for N ≥ GLITCH_CYC samples produces the same reset as R4/R5, delayed by two extra cycles of synchronisation. A request shorter than GLITCH_CYC samples is ignored.
- R7: An active-high request on `ext_rst_i` (1 = request) behaves exactly as R6 describes.
- R8: A new filtered request from any source while the timeout is running restarts the count. The release then follows the end of the last request, and the reset does not drop in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| supply_ok_i | input | 1 | Synchronous supply-good flag, 1 = supply above trip point |
| ext_rst_n_i | input | 1 | Asynchronous external reset request, active low |
| ext_rst_i | input | 1 | Asynchronous external reset request, active high |
| sys_rst_o | output | 1 | Stretched system reset, active high |
| sys_rst_n_o | output | 1 | Stretched system reset, active low |

## Verification
The embedded properties assume three things. TIMEOUT_CYC is at least 2. GLITCH_CYC is at least 1. `supply_ok_i` changes only between clock edges, so the filter sees a clean level on every cycle. The bench meets these conditions by driving every input on the falling clock edge. It uses a small configuration of four glitch cycles and a twenty-cycle timeout. On that configuration it sweeps the pulse width of each source from one cycle up to several cycles past the filter width. From the requirement formulas it computes the first reset sample and the reset length for each case. It adds a power-on case, an overlapping-request case that spans two sources, and a supply dropout much longer than the timeout.

// File: rtl/rps_pkg.sv
// Shared definitions for the reset pulse stretcher.
// Assumes: nothing beyond a standard SystemVerilog compile order.
package rps_pkg;

    // Number of flops in the input synchronisers for the asynchronous requests.
    localparam int unsigned SYNC_STAGES = 2;

    // One bit per reset source after filtering, 1 = source requests reset.
    typedef struct packed {
        logic supply;
        logic ext_lo;
        logic ext_hi;
    } rst_req_t;

endpackage

// File: rtl/rps_sync.sv
// Multi-flop synchroniser for one asynchronous bit.
// Assumes: STAGES >= 2; the output resets to RESET_VAL under synchronous rst_n.
module rps_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/rps_glitch_filter.sv
// Digital glitch filter: hit_o rises only after act_i has been sampled high on
// WIDTH_CYC consecutive edges, and it falls on the first edge that samples act_i low.
// Assumes: WIDTH_CYC >= 1 and act_i is synchronous to clk.
module rps_glitch_filter #(
    parameter int unsigned WIDTH_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    output logic hit_o
);

    localparam int unsigned CW = (WIDTH_CYC < 2) ? 1 : $clog2(WIDTH_CYC);
    localparam logic [CW-1:0] LIM = CW'(WIDTH_CYC - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive active samples (saturating) and flag a qualified request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            hit_o   <= 1'b0;
        end else if (!act_i) begin
            run_cnt <= '0;
            hit_o   <= 1'b0;
        end else begin
            hit_o <= (run_cnt >= LIM);
            if (run_cnt < LIM) run_cnt <= run_cnt + 1'b1;
        end
    end

    // An inactive sample always clears the filtered request.
    p_glitch_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !act_i |=> !hit_o);

    // A run that reaches the full width qualifies on the next edge.
    p_run_qualifies_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && run_cnt == LIM) |=> hit_o);

    // The filtered output can only rise after an active sample.
    p_rise_needs_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_o) |-> $past(act_i));

endmodule

// File: rtl/rps_timer.sv
// Shared reset timeout: any trigger loads the count and asserts the reset state;
// the state is released after TIMEOUT_CYC trigger-free edges.
// Assumes: TIMEOUT_CYC >= 2; reset starts asserted with the count loaded.
module rps_timer #(
    parameter int unsigned TIMEOUT_CYC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic active_o
);

    localparam int unsigned CW = $clog2(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] elapsed;

    // Reload on trigger, otherwise count toward release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b1;
            elapsed  <= '0;
        end else if (trig_i) begin
            active_o <= 1'b1;
            elapsed  <= '0;
        end else if (active_o) begin
            if (elapsed == LAST) active_o <= 1'b0;
            else                 elapsed  <= elapsed + 1'b1;
        end
    end

    // A trigger always leaves the reset asserted with a fresh count.
    p_retrigger_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (active_o && elapsed == '0));

    // The reset is held until the full timeout has elapsed.
    p_hold_until_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !trig_i && elapsed != LAST) |=> active_o);

    // The final count releases the reset.
    p_release_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !trig_i && elapsed == LAST) |=> !active_o);

    // With no trigger, an idle timer stays idle.
    p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !trig_i) |=> !active_o);

endmodule

// File: rtl/rps_top.sv
// Reset pulse stretcher top: filters the supply flag and the two synchronised
// external requests, merges them into one timeout, and drives both output polarities.
// Assumes: supply_ok_i is synchronous to clk; ext_* inputs may be asynchronous.
module rps_top #(
    parameter int unsigned TIMEOUT_CYC = 50_000_000,
    parameter int unsigned GLITCH_CYC  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic ext_rst_n_i,
    input  logic ext_rst_i,
    output logic sys_rst_o,
    output logic sys_rst_n_o
);

    import rps_pkg::*;

    localparam int unsigned N_EXT = 2;

    rst_req_t           req;
    logic [N_EXT-1:0]   ext_raw;
    logic [N_EXT-1:0]   ext_sync;
    logic [N_EXT-1:0]   ext_hit;
    logic               any_req;
    logic               rst_state;

    // Normalise both external pins to active-high requests.
    assign ext_raw = {ext_rst_i, ~ext_rst_n_i};

    // Supply path: already synchronous, filtered only.
    rps_glitch_filter #(.WIDTH_CYC(GLITCH_CYC)) u_flt_supply (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (~supply_ok_i),
        .hit_o (req.supply)
    );

    // External paths: synchroniser followed by glitch filter, one per pin.
    for (genvar i = 0; i < N_EXT; i++) begin : g_ext
        rps_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (ext_raw[i]),
            .q_o   (ext_sync[i])
        );
        rps_glitch_filter #(.WIDTH_CYC(GLITCH_CYC)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .act_i (ext_sync[i]),
            .hit_o (ext_hit[i])
        );
    end

    assign req.ext_lo = ext_hit[0];
    assign req.ext_hi = ext_hit[1];
    assign any_req    = |req;

    rps_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (any_req),
        .active_o (rst_state)
    );

    // Both polarities come from the single reset state.
    assign sys_rst_o   = rst_state;
    assign sys_rst_n_o = ~rst_state;

    // A qualified supply request forces the reset on the following cycle.
    p_supply_low_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req.supply |=> sys_rst_o);

    // External requests likewise force the reset on the following cycle.
    p_ext_forces_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req.ext_lo || req.ext_hi) |=> (sys_rst_o && !sys_rst_n_o));

endmodule

// File: tb/rps_top_tb.sv
// Self-checking bench for rps_top on a small configuration.
module rps_top_tb;

    localparam int T = 20;
    localparam int G = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic ext_n = 1'b1;
    logic ext_h = 1'b0;
    logic sys_rst, sys_rst_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rps_top #(.TIMEOUT_CYC(T), .GLITCH_CYC(G)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok),
        .ext_rst_n_i (ext_n),
        .ext_rst_i   (ext_h),
        .sys_rst_o   (sys_rst),
        .sys_rst_n_o (sys_rst_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive source src (0 supply, 1 active-low, 2 active-high) to level on.
    task automatic drive(input int src, input bit on);
        case (src)
            0: supply_ok = ~on;
            1: ext_n     = ~on;
            default: ext_h = on;
        endcase
    endtask

    // One pulse of width n samples; measure first reset sample and reset length.
    task automatic pulse_case(input int src, input int n);
        int first_hi = 0;
        int hi_cnt = 0;
        int bad_comp = 0;
        int off = (src == 0) ? 0 : 2;
        string tag = (src == 0) ? "R4/R5 supply" : ((src == 1) ? "R6 ext_lo" : "R7 ext_hi");
        @(negedge clk);
        drive(src, 1'b1);
        for (int k = 1; k <= n + T + 10; k++) begin
            @(negedge clk);
            if (sys_rst) begin
                hi_cnt++;
                if (first_hi == 0) first_hi = k;
            end
            if (sys_rst_n == sys_rst) bad_comp++;
            if (k == n) drive(src, 1'b0);
        end
        chk(bad_comp == 0, "R2 complement", bad_comp, 0);
        if (n < G) begin
            chk(hi_cnt == 0, (src == 0) ? "R3 short supply glitch" : tag, hi_cnt, 0);
        end else begin
            chk(first_hi == G + 1 + off, tag, first_hi, G + 1 + off);
            chk(hi_cnt == n + T - G, tag, hi_cnt, n + T - G);
        end
    endtask

    // Two requests: supply pulse, then a second source during the timeout.
    task automatic retrig_case(input int src2);
        int d = G + 8;
        int off = (src2 == 0) ? 0 : 2;
        int last_hi = 0;
        int hi_cnt = 0;
        int exp_last = d + G + T + off;
        @(negedge clk);
        drive(0, 1'b1);
        for (int k = 1; k <= exp_last + 10; k++) begin
            @(negedge clk);
            if (sys_rst) begin
                hi_cnt++;
                last_hi = k;
            end
            if (k == G) drive(0, 1'b0);
            if (k == d) drive(src2, 1'b1);
            if (k == d + G) drive(src2, 1'b0);
        end
        chk(last_hi == exp_last, "R8 release after last request", last_hi, exp_last);
        chk(hi_cnt == exp_last - G, "R8 no gap in reset", hi_cnt, exp_last - G);
    endtask

    initial begin
        int hi_cnt = 0;
        repeat (3) @(negedge clk);
        chk(sys_rst == 1'b1 && sys_rst_n == 1'b0, "R1 reset state", sys_rst, 1);
        rst_n = 1'b1;
        for (int k = 1; k <= T + 5; k++) begin
            @(negedge clk);
            if (sys_rst) hi_cnt++;
            if (k == T - 1) chk(sys_rst == 1'b1, "R1 still held", sys_rst, 1);
            if (k == T) chk(sys_rst == 1'b0, "R1 released", sys_rst, 0);
        end
        chk(hi_cnt == T - 1, "R1 power-on length", hi_cnt, T - 1);

        for (int src = 0; src < 3; src++)
            for (int n = 1; n <= G + 4; n++)
                pulse_case(src, n);

        pulse_case(0, 3 * T);   // long dropout, R4 held while low

        retrig_case(0);
        retrig_case(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule